// File: doc/BRIEF.md
# Single-Frame SPI Master with Encoded Chip-Select Setup and Hold Delays

This block drives one SPI target over a single active-low chip select. A one-cycle start strobe launches exactly one frame. The frame sends a transmit word on MOSI and gathers the bits seen on MISO into a receive word. When chip select has been released again, a one-cycle done pulse marks the end of the frame.

All timing and format settings come from a 32-bit attributes word, which is latched when the frame starts:

- frame length;
- clock polarity and clock phase;
- bit order;
- SCK half-period;
- the gap between chip select falling and the first SCK edge;
- the gap between the last SCK edge and chip select rising.

Each gap is an odd multiplier (1, 3, 5 or 7) times a power of two. This lets slow targets get long setup and hold windows while the field cost stays at six bits per gap.

In the attributes word, M(i) means 2i+1 for a two-bit index i.

Top module: `spim_top`

## Requirements
- R1: While cs_n_o is high (after reset and between frames), done_o is low except in the done cycle, mosi_o is 0, and sck_o equals bit 26 (CPOL) of attr_i as currently applied. Reset drives rx_o to zero.
- R2: A start_i that is high at a clock edge while the block is idle latches attr_i and tx_i, and cs_n_o is low from that edge on.
- R3: The first SCK edge comes D = M(attr[23:22]) × 2^(attr[15:12]+1) clocks after the edge at which cs_n_o fell.
- R4: Successive SCK edges are H = M(attr[17:16]) × 2^(attr[3:0]) clocks apart, and a frame of N bits has exactly 2N edges. SCK starts at the CPOL level.
- R5: cs_n_o rises A = M(attr[21:20]) × 2^(attr[11:8]+1) clocks after the last SCK edge.
- R6: attr[30:27] holds N−1 for frames of N = 4 to 16 bits. Codes 0 to 2 give a 4-bit frame.
- R7: With attr[24] = 0, tx_i bit N−1 is shifted out first, then down to bit 0. With attr[24] = 1, bit 0 goes first.
- R8: With attr[25] = 0, the first bit is on MOSI from the chip-select fall, MISO is captured on odd edges and MOSI changes on even edges. With attr[25] = 1, MOSI changes on odd edges from the third on (the first bit is valid from the chip-select fall) and MISO is captured on even edges.
- R9: rx_o holds the N received bits right-aligned with zeros above, using the same bit order as transmission. It updates at the edge where done_o rises and is held otherwise.
- R10: done_o is high for exactly one cycle: the first cycle in which cs_n_o is high again.
- R11: A start_i while cs_n_o is low, or in the done cycle, is ignored. The frame in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-of-frame strobe |
| attr_i | input | 32 | Transfer attributes word |
| tx_i | input | DATA_W | Word to transmit, right-aligned |
| miso_i | input | 1 | Serial data from the target |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the target |
| cs_n_o | output | 1 | Chip select, active low |
| rx_o | output | DATA_W | Last received word, right-aligned |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The assertions assume that attr_i and start_i change only between clock edges. They also assume that the attributes sampled at the start edge are the ones the frame keeps, even if attr_i moves later in the frame.

The idle-SCK property follows the live CPOL bit. It therefore accepts attr_i changing at any time while chip select is high.

The stimulus changes inputs only on the falling clock edge. It deliberately rewrites attr_i and tx_i in the middle of one frame, and it pulses start_i in the done cycle. This shows that the latched settings, not the live ones, govern the frame.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int ATTR_W  = 32;
  localparam int FRM_MAX = 16;
  localparam int NB_W    = $clog2(FRM_MAX + 1);
  localparam int TMR_W   = 20;  // 7 * 2^16 fits

  // attribute field positions (decoded by the bench and the driver side)
  localparam int A_FRM  = 27;
  localparam int A_CPOL = 26;
  localparam int A_CPHA = 25;
  localparam int A_LSB  = 24;
  localparam int A_LPRE = 22;
  localparam int A_TPRE = 20;
  localparam int A_BPRE = 16;
  localparam int A_LSC  = 12;
  localparam int A_TSC  = 8;
  localparam int A_BSC  = 0;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_XFER, S_TRAIL, S_DONE} spim_st_e;

  typedef struct packed {
    logic             cpol;
    logic             cpha;
    logic             lsb_first;
    logic [NB_W-1:0]  nbits;
    logic [TMR_W-1:0] lead;
    logic [TMR_W-1:0] half;
    logic [TMR_W-1:0] trail;
  } spim_cfg_t;

  // odd multiplier 1,3,5,7 times 2^(sc+extra)
  function automatic logic [TMR_W-1:0] scaled(input logic [1:0] pre, input logic [3:0] sc,
                                              input logic extra);
    logic [TMR_W-1:0] m;
    logic [4:0]       sh;
    m  = TMR_W'({pre, 1'b1});
    sh = {1'b0, sc} + {4'b0, extra};
    return m << sh;
  endfunction

  function automatic logic [NB_W-1:0] frame_bits(input logic [3:0] code);
    return (code < 4'd3) ? NB_W'(4) : NB_W'(code) + NB_W'(1);
  endfunction
endpackage

// File: rtl/spim_cfg_dec.sv
module spim_cfg_dec
  import spim_pkg::*;
(
  input  logic [ATTR_W-1:0] attr_i,
  output spim_cfg_t         cfg_o
);
  always_comb begin
    cfg_o.cpol      = attr_i[A_CPOL];
    cfg_o.cpha      = attr_i[A_CPHA];
    cfg_o.lsb_first = attr_i[A_LSB];
    cfg_o.nbits     = frame_bits(attr_i[A_FRM+:4]);
    cfg_o.lead      = scaled(attr_i[A_LPRE+:2], attr_i[A_LSC+:4], 1'b1);
    cfg_o.trail     = scaled(attr_i[A_TPRE+:2], attr_i[A_TSC+:4], 1'b1);
    cfg_o.half      = scaled(attr_i[A_BPRE+:2], attr_i[A_BSC+:4], 1'b0);
  end

  logic unused_attr;
  assign unused_attr = ^{attr_i[31], attr_i[19:18], attr_i[7:4]};
endmodule

// File: rtl/spim_timer.sv
module spim_timer #(
  parameter int CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int DATA_W = 16,
  parameter int NB_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic              lsb_i,
  input  logic [NB_W-1:0]   nbits_i,
  input  logic              shift_i,
  input  logic              capture_i,
  input  logic              finish_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] tx_q, rx_sh_q, rx_q;
  logic [IDX_W-1:0]  out_q, in_q, out_pos, in_pos;
  logic [NB_W-1:0]   out_w, in_w;

  // bit order: index counts transmitted bits, position maps it into the word
  assign out_w   = lsb_i ? NB_W'(out_q) : nbits_i - NB_W'(1) - NB_W'(out_q);
  assign in_w    = lsb_i ? NB_W'(in_q)  : nbits_i - NB_W'(1) - NB_W'(in_q);
  assign out_pos = out_w[IDX_W-1:0];
  assign in_pos  = in_w[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q    <= '0;
      rx_sh_q <= '0;
      rx_q    <= '0;
      out_q   <= '0;
      in_q    <= '0;
    end else if (load_i) begin
      tx_q    <= tx_i;
      rx_sh_q <= '0;
      out_q   <= '0;
      in_q    <= '0;
    end else begin
      if (shift_i) out_q <= out_q + 1'b1;
      if (capture_i) begin
        rx_sh_q[in_pos] <= miso_i;
        in_q            <= in_q + 1'b1;
      end
      if (finish_i) rx_q <= rx_sh_q;
    end
  end

  assign mosi_o = tx_q[out_pos];
  assign rx_o   = rx_q;

  logic unused_w;
  assign unused_w = ^{out_w[NB_W-1:IDX_W], in_w[NB_W-1:IDX_W]};
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int DATA_W = FRM_MAX
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ATTR_W-1:0] attr_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic              miso_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              cs_n_o,
  output logic [DATA_W-1:0] rx_o,
  output logic              done_o
);
  localparam int EDGE_W = $clog2(2 * DATA_W + 1);

  spim_st_e          state_q;
  spim_cfg_t         cfg_d, cfg_q;
  logic              cs_n_q, sck_q, done_q;
  logic [EDGE_W-1:0] edge_q, edge_num;
  logic              tmr_load, tmr_zero;
  logic [TMR_W-1:0]  tmr_val;
  logic              edge_ev, last_edge, capture_ev, shift_ev, finish, mosi_bit;

  spim_cfg_dec u_dec (.attr_i(attr_i), .cfg_o(cfg_d));

  spim_timer #(.CNT_W(TMR_W)) u_tmr (
    .clk_i, .rst_ni, .load_i(tmr_load), .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  assign edge_ev    = ((state_q == S_LEAD) || (state_q == S_XFER)) && tmr_zero;
  assign edge_num   = edge_q + 1'b1;
  assign last_edge  = (edge_num == EDGE_W'({cfg_q.nbits, 1'b0}));
  assign capture_ev = edge_ev && (edge_num[0] ^ cfg_q.cpha);
  // first-bit data is already on the line: cpha=1 skips edge 1, cpha=0 skips the final edge
  assign shift_ev   = edge_ev && !(edge_num[0] ^ cfg_q.cpha) &&
                      (cfg_q.cpha ? (edge_num != EDGE_W'(1)) : !last_edge);
  assign finish     = (state_q == S_TRAIL) && tmr_zero;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        tmr_load = 1'b1;
        tmr_val  = cfg_d.lead - 1'b1;
      end
      S_LEAD, S_XFER: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = last_edge ? cfg_q.trail - 1'b1 : cfg_q.half - 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cfg_q   <= '0;
      cs_n_q  <= 1'b1;
      sck_q   <= 1'b0;
      done_q  <= 1'b0;
      edge_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          cfg_q   <= cfg_d;
          cs_n_q  <= 1'b0;
          sck_q   <= cfg_d.cpol;
          edge_q  <= '0;
          state_q <= S_LEAD;
        end
        S_LEAD, S_XFER: if (tmr_zero) begin
          sck_q   <= ~sck_q;
          edge_q  <= edge_num;
          state_q <= last_edge ? S_TRAIL : S_XFER;
        end
        S_TRAIL: if (tmr_zero) begin
          cs_n_q  <= 1'b1;
          done_q  <= 1'b1;
          state_q <= S_DONE;
        end
        default: begin
          done_q  <= 1'b0;
          state_q <= S_IDLE;
        end
      endcase
    end
  end

  spim_shift #(.DATA_W(DATA_W), .NB_W(NB_W)) u_shift (
    .clk_i, .rst_ni,
    .load_i   ((state_q == S_IDLE) && start_i),
    .tx_i     (tx_i),
    .lsb_i    (cfg_q.lsb_first),
    .nbits_i  (cfg_q.nbits),
    .shift_i  (shift_ev),
    .capture_i(capture_ev),
    .finish_i (finish),
    .miso_i   (miso_i),
    .mosi_o   (mosi_bit),
    .rx_o     (rx_o)
  );

  assign cs_n_o = cs_n_q;
  assign sck_o  = cs_n_q ? attr_i[A_CPOL] : sck_q;
  assign mosi_o = !cs_n_q && mosi_bit;
  assign done_o = done_q;

  logic unused_cfg;
  assign unused_cfg = ^{cfg_q.lead, cfg_q.cpol};
endmodule

// File: rtl/spim_chk.sv
module spim_chk
  import spim_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ATTR_W-1:0] attr_i,
  input logic              cs_n_o,
  input logic              sck_o,
  input logic              mosi_o,
  input logic              done_o
);
  logic             sck_prev_q;
  logic [5:0]       tog_q;
  logic [NB_W-1:0]  nb_q;
  logic [TMR_W-1:0] lead_q, dly_q;
  logic             sck_chg;

  assign sck_chg = !cs_n_o && (sck_o != sck_prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_prev_q <= 1'b0;
      tog_q      <= '0;
      nb_q       <= '0;
      lead_q     <= '0;
      dly_q      <= '0;
    end else begin
      sck_prev_q <= sck_o;
      if (cs_n_o) begin
        tog_q  <= '0;
        lead_q <= '0;
        nb_q   <= frame_bits(attr_i[A_FRM+:4]);
        dly_q  <= scaled(attr_i[A_LPRE+:2], attr_i[A_LSC+:4], 1'b1);
      end else if (sck_chg) begin
        tog_q <= tog_q + 1'b1;
      end else if (tog_q == '0) begin
        lead_q <= lead_q + 1'b1;
      end
    end
  end

  AST_IDLE_SCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> (sck_o == attr_i[A_CPOL])); // R1
  AST_IDLE_MOSI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> !mosi_o); // R1
  AST_CS_FALL_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_o) |-> $past(start_i)); // R2
  AST_LEAD_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_chg && (tog_q == '0)) |-> (lead_q == dly_q)); // R3
  AST_EDGE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (tog_q == 6'({nb_q, 1'b0}))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_DONE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $rose(cs_n_o)); // R10
  AST_CS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_o |=> (!cs_n_o || done_o)); // R11

  logic unused_attr;
  assign unused_attr = ^attr_i;
endmodule

bind spim_top spim_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .attr_i(attr_i),
  .cs_n_o(cs_n_o), .sck_o(sck_o), .mosi_o(mosi_o), .done_o(done_o)
);

// File: tb/spim_top_tb_top.sv
`timescale 1ns/1ps
module spim_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] attr_i = '0;
  logic [15:0] tx_i = '0;
  logic        miso_i = 1'b0;
  logic        sck_o, mosi_o, cs_n_o, done_o;
  logic [15:0] rx_o;

  always #2.5 clk = ~clk;

  spim_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .attr_i(attr_i), .tx_i(tx_i),
    .miso_i(miso_i), .sck_o(sck_o), .mosi_o(mosi_o), .cs_n_o(cs_n_o), .rx_o(rx_o),
    .done_o(done_o)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit run_chk = 0, finished = 0;

  task automatic chk(input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
    n_cmp++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  function automatic int nbits_of(input logic [31:0] a);
    return (a[30:27] < 3) ? 4 : int'(a[30:27]) + 1;
  endfunction
  function automatic int dly(input logic [1:0] p, input logic [3:0] s, input int x);
    return (2 * int'(p) + 1) * (1 << (int'(s) + x));
  endfunction
  function automatic logic [31:0] mk(input bit cpol, input bit cpha, input bit lsb, input int code,
                                     input int lp, input int ls, input int tp, input int ts,
                                     input int bp, input int bs);
    logic [31:0] a = '0;
    a[30:27] = code[3:0]; a[26] = cpol; a[25] = cpha; a[24] = lsb;
    a[23:22] = lp[1:0]; a[15:12] = ls[3:0]; a[21:20] = tp[1:0]; a[11:8] = ts[3:0];
    a[17:16] = bp[1:0]; a[3:0] = bs[3:0];
    return a;
  endfunction

  // behavioural reference: cycles since the accepting edge
  bit m_busy = 0, m_cpol, m_cpha, m_lsb;
  int m_k, m_d, m_h, m_a, m_n;
  logic [15:0] m_tx;

  function automatic int m_total();
    return m_d + (2 * m_n - 1) * m_h + m_a;
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) m_busy = 0;
    else begin
      if (m_busy) begin
        m_k++;
        if (m_k == m_total() + 2) m_busy = 0;
      end
      if (!m_busy && start_i) begin
        m_busy = 1; m_k = 0; m_tx = tx_i;
        m_cpol = attr_i[26]; m_cpha = attr_i[25]; m_lsb = attr_i[24];
        m_n = nbits_of(attr_i);
        m_d = dly(attr_i[23:22], attr_i[15:12], 1);
        m_h = dly(attr_i[17:16], attr_i[3:0], 0);
        m_a = dly(attr_i[21:20], attr_i[11:8], 1);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_ni && run_chk) begin
      int  e, idx;
      bit  low;
      logic ex_sck, ex_mosi;
      low = m_busy && (m_k < m_total());
      e = (m_k < m_d) ? 0 : (m_k - m_d) / m_h + 1;
      if (e > 2 * m_n) e = 2 * m_n;
      if (m_cpha) idx = (e == 0) ? 0 : (e - 1) / 2;
      else begin idx = e / 2; if (idx > m_n - 1) idx = m_n - 1; end
      ex_sck  = low ? (m_cpol ^ e[0]) : attr_i[26];
      ex_mosi = low ? m_tx[m_lsb ? idx : m_n - 1 - idx] : 1'b0;
      chk("R5 cs_n", 32'(cs_n_o), 32'(!low));
      chk("R4 sck", 32'(sck_o), 32'(ex_sck));
      chk("R8 mosi", 32'(mosi_o), 32'(ex_mosi));
      chk("R10 done", 32'(done_o), 32'(m_busy && (m_k == m_total())));
    end
  end

  // target model: drives MISO, captures MOSI, measures lead gap and edge count
  int t_n = 8, s_e = 0, s_cnt = 0, s_lead = 0, s_cap = 0;
  bit t_cpha = 0, t_lsb = 0, s_prev_cs = 1, s_prev_sck = 0;
  logic [15:0] t_pat = '0, s_rx = '0;

  function automatic int tpos(input int i);
    return t_lsb ? i : t_n - 1 - i;
  endfunction

  always @(negedge clk) begin
    if (!cs_n_o) begin
      int oi;
      if (s_prev_cs) begin
        s_e = 0; s_cnt = 0; s_lead = -1; s_rx = '0; s_cap = 0;
      end else begin
        s_cnt++;
        if (sck_o !== s_prev_sck) begin
          s_e++;
          if (s_e == 1) s_lead = s_cnt;
          if (((s_e % 2) == 1) != t_cpha) begin
            s_rx[tpos(s_cap)] = mosi_o;
            s_cap++;
          end
        end
      end
      if (t_cpha) oi = (s_e == 0) ? 0 : (s_e - 1) / 2;
      else begin oi = s_e / 2; if (oi > t_n - 1) oi = t_n - 1; end
      miso_i = t_pat[tpos(oi)];
    end else miso_i = 1'b0;
    s_prev_cs  = cs_n_o;
    s_prev_sck = sck_o;
  end

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      report();
    end
  end

  task automatic run_frame(input logic [31:0] a, input logic [15:0] tx, input logic [15:0] pat,
                           input bit poke);
    logic [15:0] mask;
    t_n = nbits_of(a); t_cpha = a[25]; t_lsb = a[24]; t_pat = pat;
    mask = 16'((32'd1 << t_n) - 1);
    @(negedge clk); attr_i = a; tx_i = tx; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk("R2 cs low after start", 32'(cs_n_o), 32'd0);
    if (poke) begin
      repeat (5) @(negedge clk);
      start_i = 1'b1; tx_i = ~tx; attr_i = a ^ 32'h0780_F00F;
      @(negedge clk); start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    chk("R9 rx word", 32'(rx_o), 32'(pat & mask));
    chk("R7 target got tx", 32'(s_rx), 32'(tx & mask));
    chk("R6 edge count", 32'(s_e), 32'(2 * t_n));
    chk("R3 lead gap", 32'(s_lead), 32'(dly(a[23:22], a[15:12], 1)));
    if (poke) chk("R11 busy start ignored", 32'(s_rx), 32'(tx & mask));
    start_i = 1'b1;  // lands in the done cycle
    @(negedge clk); start_i = 1'b0;
    chk("R11 done-cycle start ignored", 32'(cs_n_o), 32'd1);
    chk("R9 rx held", 32'(rx_o), 32'(pat & mask));
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset cs_n", 32'(cs_n_o), 32'd1);
    chk("R1 reset done", 32'(done_o), 32'd0);
    chk("R1 reset mosi", 32'(mosi_o), 32'd0);
    chk("R1 reset rx", 32'(rx_o), 32'd0);
    rst_ni = 1'b1;
    run_chk = 1;
    @(negedge clk);
    attr_i = 32'h0400_0000;
    @(negedge clk);
    chk("R1 idle sck follows cpol", 32'(sck_o), 32'd1);
    run_frame(mk(0, 0, 0, 7, 0, 0, 1, 0, 0, 0), 16'h00A5, 16'h003C, 0);
    run_frame(mk(1, 1, 1, 15, 1, 1, 0, 0, 1, 1), 16'hC3E1, 16'h5A96, 0);
    run_frame(mk(1, 0, 0, 3, 0, 1, 0, 1, 0, 2), 16'h0009, 16'h0006, 0);
    run_frame(mk(0, 1, 0, 4, 3, 2, 2, 1, 2, 0), 16'h0015, 16'h000B, 0);
    run_frame(mk(0, 0, 1, 1, 0, 0, 0, 0, 0, 0), 16'hFFF6, 16'hFFF9, 0);  // R6 short code
    run_frame(mk(1, 1, 0, 11, 2, 0, 1, 1, 0, 1), 16'h0B7D, 16'h04E2, 1);
    run_frame(mk(0, 1, 1, 9, 0, 9, 0, 10, 0, 0), 16'h0355, 16'h02AA, 0);
    repeat (3) @(negedge clk);
    report();
  end
endmodule